// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the faster module clock. A control word packs two divisor fields and a law-select bit. One law divides the module clock by twice one more than an 8-bit value. The other divides it by a power of two given by a 4-bit exponent. The serial clock keeps a 50 percent duty cycle, and its resting level follows the clock polarity input.

The block also drives two one-cycle strobes for the shift engine. `lead_stb` marks the edge where the serial clock leaves its resting level. `trail_stb` marks the edge where it returns. The shift engine raises `en` to start a transfer and lowers it to stop. The divisor and the polarity are captured when the block starts, so a control word written during a transfer can never shorten a pulse.

The state machine has three states:
- `ST_IDLE`: disabled. The serial clock rests at the polarity level.
- `ST_REST_PH`: the first half period, with the serial clock at the resting level.
- `ST_DRIVE_PH`: the second half period, with the serial clock at the opposite level.

It has four transitions:
- T_START, `ST_IDLE` to `ST_REST_PH`, when `en` is high. This captures the word and the polarity.
- T_LEAD, `ST_REST_PH` to `ST_DRIVE_PH`, when the half-period count expires. This raises `lead_stb`.
- T_TRAIL, `ST_DRIVE_PH` to `ST_REST_PH`, when the count expires. This raises `trail_stb`.
- T_STOP, from either active state to `ST_IDLE`, when `en` is low.

Top module: `sclk_divgen`

## Requirements
- R1: With `div_word[12]` = 1 (linear law), each half period of `sclk` lasts N+1 module clock cycles, where N = `div_word[7:0]`. The full period is therefore 2*(N+1) cycles.
- R2: With `div_word[12]` = 0 (exponential law) and E = `div_word[11:8]` of 1 or more, each half period lasts 2^(E-1) cycles. The full period is therefore 2^E cycles.
- R3: The field of the law that is not selected has no effect on the period.
- R4: The shortest settings give a period of two module clocks: linear N=0, exponential E=0 and exponential E=1.
- R5: `div_word` and `cpol` are captured on the clock edge that leaves `ST_IDLE`. Changes made while active have no effect until the block has passed through `ST_IDLE` again.
- R6: During reset, and from the first edge after `en` is sampled low, `sclk` equals the live `cpol` and both strobes are low.
- R7: Each strobe lasts one cycle. Strobes alternate, starting with `lead_stb`. In the cycle of `lead_stb`, `sclk` equals the opposite of the captured `cpol`. In the cycle of `trail_stb`, `sclk` equals the captured `cpol`.
- R8: The first `lead_stb` appears one half period after the start edge, so the first half period is spent at the resting level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mod | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request from the shift engine |
| div_word | input | 13 | Control word: [7:0] linear N, [11:8] exponent E, [12] law select (1 = linear) |
| cpol | input | 1 | Resting level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe when `sclk` leaves its resting level |
| trail_stb | output | 1 | One-cycle strobe when `sclk` returns to its resting level |

## Verification
The bench builds the block with its default widths: an 8-bit linear field and a 4-bit exponent. With these widths it can reach both ends of each law. At the long end, the linear N=255 gives a 256-cycle half period and the exponent 15 gives a 16384-cycle half period. At the short end, the three settings that give a one-cycle half period can be checked one after another. The default widths also place the law-select bit at bit 12, so the vectors can set values in the unused field and check that they are ignored.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REST_PH  = 2'd1,
        ST_DRIVE_PH = 2'd2
    } sdiv_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdiv_word_decode.sv
module sdiv_word_decode #(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int HALF_W = 15
) (
    input  logic [LIN_W+EXP_W:0] ctrl_word,
    output logic [HALF_W-1:0]    half_cyc
);
    localparam int SEL_BIT = LIN_W + EXP_W;
    localparam int N_EXP   = 2 ** EXP_W;

    logic [LIN_W-1:0]  lin_f;
    logic [EXP_W-1:0]  exp_f;
    logic              lin_sel;
    logic [HALF_W-1:0] lin_half;
    logic [HALF_W-1:0] pow_tbl [N_EXP];

    assign lin_f   = ctrl_word[LIN_W-1:0];
    assign exp_f   = ctrl_word[SEL_BIT-1:LIN_W];
    assign lin_sel = ctrl_word[SEL_BIT];

    // Linear law: half period of N+1 module cycles
    assign lin_half = HALF_W'(lin_f) + HALF_W'(1);

    // Exponential law: half period of 2^(E-1); E=0 folds onto E=1 (R4)
    for (genvar k = 0; k < N_EXP; k++) begin : g_pow
        if (k == 0) begin : g_floor
            assign pow_tbl[k] = HALF_W'(1);
        end else begin : g_shift
            assign pow_tbl[k] = HALF_W'(1) << (k - 1);
        end
    end

    // R3: only the selected field reaches the output
    assign half_cyc = lin_sel ? lin_half : pow_tbl[exp_f];

endmodule

// File: rtl/sdiv_cfg_hold.sv
module sdiv_cfg_hold #(
    parameter int HALF_W = 15
) (
    input  logic              clk_mod,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] half_in,
    input  logic              cpol_in,
    output logic [HALF_W-1:0] half_q,
    output logic              cpol_q
);

    // R5: configuration is captured only while the divider is idle
    always_ff @(posedge clk_mod or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= HALF_W'(1);
            cpol_q <= 1'b0;
        end else if (load) begin
            half_q <= half_in;
            cpol_q <= cpol_in;
        end
    end

    // R4: whatever was captured, the half period is at least one cycle
    a_r4_half_nonzero: assert property (
        @(posedge clk_mod) disable iff (!rst_n)
        load |=> (half_q != '0)
    );

endmodule

// File: rtl/sdiv_phase_fsm.sv
module sdiv_phase_fsm
    import sdiv_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  logic              clk_mod,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half_live,
    input  logic [HALF_W-1:0] half_q,
    input  logic              cpol_live,
    input  logic              cpol_q,
    output logic              is_idle,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb
);
    localparam int DW_W = HALF_W + 1;

    sdiv_state_e       state;
    sdiv_state_e       nxt;
    logic [HALF_W-1:0] cnt;
    logic              cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign is_idle  = (state == ST_IDLE);

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (en) nxt = ST_REST_PH;                 // T_START
            end
            ST_REST_PH: begin
                if (!en)          nxt = ST_IDLE;          // T_STOP
                else if (cnt_zero) nxt = ST_DRIVE_PH;     // T_LEAD
            end
            ST_DRIVE_PH: begin
                if (!en)          nxt = ST_IDLE;          // T_STOP
                else if (cnt_zero) nxt = ST_REST_PH;      // T_TRAIL
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_mod or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Half-period counter
    always_ff @(posedge clk_mod or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (nxt != state) begin
            cnt <= (state == ST_IDLE) ? (half_live - HALF_W'(1))
                                      : (half_q - HALF_W'(1));
        end else if (state != ST_IDLE) begin
            cnt <= cnt - HALF_W'(1);
        end
    end

    // Output register: strobes coincide with the sclk change
    always_ff @(posedge clk_mod or negedge rst_n) begin
        if (!rst_n) begin
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            lead_stb  <= (state == ST_REST_PH)  && (nxt == ST_DRIVE_PH);
            trail_stb <= (state == ST_DRIVE_PH) && (nxt == ST_REST_PH);
        end
    end

    // Serial clock: live polarity when idle, captured polarity when active
    always_comb begin
        unique case (state)
            ST_IDLE:     sclk = cpol_live;
            ST_REST_PH:  sclk = cpol_q;
            ST_DRIVE_PH: sclk = ~cpol_q;
            default:     sclk = cpol_live;
        endcase
    end

    // ---------------- checking logic ----------------
    logic [DW_W-1:0] dwell;
    logic            last_was_lead;

    always_ff @(posedge clk_mod or negedge rst_n) begin
        if (!rst_n) begin
            dwell         <= DW_W'(1);
            last_was_lead <= 1'b0;
        end else begin
            if (nxt != state)      dwell <= DW_W'(1);
            else if (dwell != '1)  dwell <= dwell + DW_W'(1);
            if (state == ST_IDLE)  last_was_lead <= 1'b0;
            else if (lead_stb)     last_was_lead <= 1'b1;
            else if (trail_stb)    last_was_lead <= 1'b0;
        end
    end

    // R1 R2: every completed phase lasts exactly the captured half period
    a_r1_half_len: assert property (
        @(posedge clk_mod) disable iff (!rst_n)
        (state != ST_IDLE && nxt != state && nxt != ST_IDLE)
            |-> (dwell == {1'b0, half_q})
    );

    // R6: disabled means resting clock and quiet strobes
    a_r6_quiet_when_off: assert property (
        @(posedge clk_mod) disable iff (!rst_n)
        !en |=> (!lead_stb && !trail_stb && sclk == cpol_live)
    );

    // R7: strobes are single-cycle
    a_r7_lead_single: assert property (
        @(posedge clk_mod) disable iff (!rst_n)
        lead_stb |=> !lead_stb
    );

    // R7: strobes alternate, leading first
    a_r7_alternate: assert property (
        @(posedge clk_mod) disable iff (!rst_n)
        (lead_stb |-> !last_was_lead) and (trail_stb |-> last_was_lead)
    );

    // R7: sclk level at each strobe
    a_r7_level: assert property (
        @(posedge clk_mod) disable iff (!rst_n)
        (lead_stb |-> sclk == ~cpol_q) and (trail_stb |-> sclk == cpol_q)
    );

endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
    import sdiv_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic                   clk_mod,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [LIN_W+EXP_W:0]   div_word,
    input  logic                   cpol,
    output logic                   sclk,
    output logic                   lead_stb,
    output logic                   trail_stb
);
    // Wide enough for N+1 and for 2^(2^EXP_W - 2)
    localparam int HALF_W = max_int(LIN_W + 1, (2 ** EXP_W) - 1);

    logic [HALF_W-1:0] half_live;
    logic [HALF_W-1:0] half_q;
    logic              cpol_q;
    logic              is_idle;

    sdiv_word_decode #(
        .LIN_W  (LIN_W),
        .EXP_W  (EXP_W),
        .HALF_W (HALF_W)
    ) u_decode (
        .ctrl_word (div_word),
        .half_cyc  (half_live)
    );

    sdiv_cfg_hold #(
        .HALF_W (HALF_W)
    ) u_hold (
        .clk_mod (clk_mod),
        .rst_n   (rst_n),
        .load    (is_idle),
        .half_in (half_live),
        .cpol_in (cpol),
        .half_q  (half_q),
        .cpol_q  (cpol_q)
    );

    sdiv_phase_fsm #(
        .HALF_W (HALF_W)
    ) u_fsm (
        .clk_mod   (clk_mod),
        .rst_n     (rst_n),
        .en        (en),
        .half_live (half_live),
        .half_q    (half_q),
        .cpol_live (cpol),
        .cpol_q    (cpol_q),
        .is_idle   (is_idle),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

endmodule

// File: tb/test_sclk_divgen.sv
module test_sclk_divgen;

    logic        clk_mod = 1'b0;
    logic        rst_n   = 1'b0;
    logic        en      = 1'b0;
    logic [12:0] div_word = '0;
    logic        cpol    = 1'b0;
    logic        sclk, lead_stb, trail_stb;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk_mod = ~clk_mod;   // 125 MHz

    sclk_divgen i_sclk_divgen (
        .clk_mod   (clk_mod),
        .rst_n     (rst_n),
        .en        (en),
        .div_word  (div_word),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    // {half period, requirement, 2'b0, cpol, word}
    localparam int NV = 9;
    localparam logic [47:0] VECS [NV] = '{
        {24'd1,     8'd4, 2'b00, 1'b0, 13'h1500},  // linear N=0, exp field set
        {24'd4,     8'd3, 2'b00, 1'b1, 13'h1A03},  // linear N=3, exp field ignored
        {24'd256,   8'd1, 2'b00, 1'b0, 13'h10FF},  // linear N=255
        {24'd101,   8'd1, 2'b00, 1'b1, 13'h1064},  // linear N=100
        {24'd1,     8'd4, 2'b00, 1'b1, 13'h0037},  // exp E=0, lin field ignored
        {24'd1,     8'd4, 2'b00, 1'b0, 13'h0100},  // exp E=1
        {24'd8,     8'd3, 2'b00, 1'b1, 13'h04FF},  // exp E=4, lin field ignored
        {24'd256,   8'd2, 2'b00, 1'b0, 13'h0900},  // exp E=9
        {24'd16384, 8'd2, 2'b00, 1'b1, 13'h0F00}   // exp E=15
    };

    function automatic string tag(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for the next strobe; returns negedges counted
    task automatic wait_stb(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk_mod);
            n++;
        end while (!(lead_stb || trail_stb) && n < limit);
    endtask

    // Start, then check first leading edge and ngap further half periods
    task automatic run_one(input logic [12:0] w, input logic cp, input int h,
                           input string req, input int ngap);
        int n;
        @(negedge clk_mod);
        div_word = w; cpol = cp; en = 1'b0;
        @(negedge clk_mod);
        chk(sclk == cp && !lead_stb && !trail_stb, "R6", "idle level",
            int'(sclk), int'(cp));
        en = 1'b1;
        wait_stb(h + 4, n);
        chk(n == h + 1, "R8", {req, " first lead latency"}, n, h + 1);
        chk(lead_stb == 1'b1 && sclk == ~cp, "R7", "first strobe is lead",
            int'(lead_stb), 1);
        for (int g = 1; g <= ngap; g++) begin
            wait_stb(h + 4, n);
            chk(n == h, req, "half period", n, h);
            if (g % 2 == 1)
                chk(trail_stb && !lead_stb && sclk == cp, "R7", "trail level",
                    int'(sclk), int'(cp));
            else
                chk(lead_stb && !trail_stb && sclk == ~cp, "R7", "lead level",
                    int'(sclk), int'(~cp));
        end
        en = 1'b0;
        @(negedge clk_mod);
        chk(sclk == cp && !lead_stb && !trail_stb, "R6", "stop quiet",
            int'(lead_stb || trail_stb), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_mod);
        n_fail++;
        $display("FAIL R7 watchdog: got %0d cycles expected fewer", 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        // Reset state: en high is ignored, sclk follows cpol (R6)
        en = 1'b1; cpol = 1'b1;
        repeat (3) @(negedge clk_mod);
        chk(sclk == 1'b1 && !lead_stb && !trail_stb, "R6", "reset level cpol=1",
            int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk_mod);
        chk(sclk == 1'b0 && !lead_stb && !trail_stb, "R6", "reset level cpol=0",
            int'(sclk), 0);
        en = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk_mod);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i][12:0], VECS[i][13], int'(VECS[i][47:24]),
                    tag(int'(VECS[i][23:16])), 3);
        end

        // R5: changes while running are ignored until idle
        @(negedge clk_mod);
        div_word = 13'h1003; cpol = 1'b0;
        @(negedge clk_mod);
        en = 1'b1;
        wait_stb(10, n);
        chk(n == 5 && lead_stb, "R5", "start lead", n, 5);
        div_word = 13'h1000; cpol = 1'b1;
        wait_stb(10, n);
        chk(n == 4, "R5", "old period kept", n, 4);
        chk(trail_stb && sclk == 1'b0, "R5", "old cpol kept", int'(sclk), 0);
        wait_stb(10, n);
        chk(n == 4 && lead_stb && sclk == 1'b1, "R5", "old settings lead",
            n, 4);
        en = 1'b0;
        @(negedge clk_mod);
        chk(sclk == 1'b1 && !lead_stb && !trail_stb, "R6", "new cpol when idle",
            int'(sclk), 1);
        en = 1'b1;
        wait_stb(10, n);
        chk(n == 2 && lead_stb && sclk == 1'b0, "R5", "new word after idle",
            n, 2);
        wait_stb(10, n);
        chk(n == 1 && trail_stb && sclk == 1'b1, "R5", "new half period",
            n, 1);

        // R6: stop in the middle of the driven phase
        en = 1'b0;
        @(negedge clk_mod);
        div_word = 13'h04FF; cpol = 1'b1;
        @(negedge clk_mod);
        en = 1'b1;
        wait_stb(20, n);
        chk(n == 9 && lead_stb, "R8", "exp E=4 first lead", n, 9);
        repeat (3) @(negedge clk_mod);
        en = 1'b0;
        begin
            int quiet = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk_mod);
                if (!lead_stb && !trail_stb && sclk == 1'b1) quiet++;
            end
            chk(quiet == 20, "R6", "mid-phase stop quiet cycles", quiet, 20);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule